// File: doc/BRIEF.md
# Potentiometer Register Bank with Nonvolatile Write Sequencer

This block holds the settings of four digitally controlled potentiometers. Each potentiometer has four 6-bit stored settings, sixteen in all, kept in ordinary flip-flops. Each potentiometer also has a live wiper position register. A serial-bus decoder sits upstream. It passes each decoded register command in as a one-cycle request with an operation code, a potentiometer select, a register select and a data byte. It also sends a separate pulse when the bus stop condition ends the transaction. The block returns read data, drives the four wiper positions, and pulses a per-wiper load strobe whenever a position is loaded.

Writing a stored setting models a slow nonvolatile store. The command is first held in an armed state. The write lands on the stop pulse, and a busy window of `BUSY_CYCLES` clocks follows. A write-protect input that is low drops every such store and raises no busy. Wiper-only operations take effect at once. After reset the block recalls stored setting 0 of every potentiometer into its wiper before it accepts commands.

The controller has four states. In RECALL, reached from reset, all wipers are loaded from setting 0, and the next state is IDLE. In IDLE, commands are accepted. A nonvolatile command with write enable goes to ARMED; anything else stays in IDLE. In ARMED, the captured store waits for the stop pulse, and that pulse goes to BUSY. In BUSY, the timer runs, and its last cycle returns to IDLE.

Top module: `potbank_seq`

## Requirements
- R1: While reset is held, and during the RECALL cycle, busy is 1. In the first cycle after reset is released, every wiper holds its stored setting 0 and wiper_load is 4'b1111 for one cycle. After reset, stored setting (pot p, reg r) is (p*4 + r + 5) mod 64.
- R2: Op code 2 (write wiper) loads cmd_data[5:0] into the wiper of cmd_pot. The new value is visible one cycle after the request, and wiper_load pulses only bit cmd_pot for that cycle.
- R3: Op code 1 (read wiper) and op code 3 (read setting cmd_pot/cmd_reg) return the value on rd_data one cycle after the request, with rd_valid high for that cycle. Bits [7:6] of rd_data are 0.
- R4: Op code 4 (write setting) with wp_n high stores cmd_data into setting (cmd_pot, cmd_reg) at the bus_stop pulse. busy is then high for exactly BUSY_CYCLES cycles, starting in the cycle after the stop.
- R5: Op code 5 copies setting (cmd_pot, cmd_reg) into that pot's wiper one cycle after the request. It strobes that wiper and raises no busy.
- R6: Op code 6 copies the wiper of cmd_pot into setting (cmd_pot, cmd_reg), with the same stop and busy timing as R4.
- R7: Op code 7 copies setting cmd_reg of all four pots into their wipers in one cycle, with wiper_load 4'b1111.
- R8: Op code 8 copies all four wipers into their setting cmd_reg, with the same stop and busy timing as R4.
- R9: With wp_n low, op codes 4, 6 and 8 change no stored setting and raise no busy, even after bus_stop. Wiper operations still work.
- R10: Requests that arrive while busy, or while a store is armed and waiting for its stop, change no wiper, give no read and produce no strobe.
- R11: Op codes 0 and 9 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write enable for stored settings; low blocks them |
| cmd_valid | input | 1 | One-cycle command request |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_pot | input | 2 | Potentiometer select |
| cmd_reg | input | 2 | Stored-setting select |
| cmd_data | input | 6 | Write data |
| bus_stop | input | 1 | Pulse marking the end of the bus transaction |
| busy | output | 1 | Recall or nonvolatile write in progress |
| rd_valid | output | 1 | rd_data is valid this cycle |
| rd_data | output | 8 | Read value, zero-padded to a byte |
| wiper_load | output | 4 | Per-wiper load strobe |
| wiper_pos | output | 24 | Wiper positions, pot p in bits [6p+5:6p] |

## Verification
Immediate operations are due one cycle after the request: reads, wiper writes, single and global transfers into wipers, and the recall after reset. The bench drives each request on a falling edge and samples one falling edge later. For stores, busy is sampled at the falling edge after the stop pulse. The bench then counts the falling edges with busy high and compares the count with BUSY_CYCLES. Each store is confirmed by a later read. Random operations are checked against a bench model of all sixteen settings and four wipers, and directed cases cover write protect and requests made while armed or busy.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_RD_WIP  = 4'd1,
        OP_WR_WIP  = 4'd2,
        OP_RD_SET  = 4'd3,
        OP_WR_SET  = 4'd4,
        OP_SET2WIP = 4'd5,
        OP_WIP2SET = 4'd6,
        OP_G_S2W   = 4'd7,
        OP_G_W2S   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_RECALL,
        ST_IDLE,
        ST_ARMED,
        ST_BUSY
    } state_e;

    function automatic logic is_store(input logic [3:0] op);
        return (op == OP_WR_SET) || (op == OP_WIP2SET) || (op == OP_G_W2S);
    endfunction
endpackage

// File: rtl/potbank_regfile.sv
module potbank_regfile #(
    parameter int NUM_POTS  = 4,
    parameter int NUM_REGS  = 4,
    parameter int DW        = 6,
    parameter int INIT_BASE = 5,
    localparam int RW       = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_POTS-1:0]               we,
    input  logic [RW-1:0]                     wsel,
    input  logic [NUM_POTS*DW-1:0]            wdata,
    output logic [NUM_POTS*NUM_REGS*DW-1:0]   rd_all
);
    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            localparam int IDX = p * NUM_REGS + r;
            logic [DW-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cell_q <= DW'(IDX + INIT_BASE);
                else if (we[p] && (wsel == RW'(r)))
                    cell_q <= wdata[p*DW +: DW];
            end
            assign rd_all[IDX*DW +: DW] = cell_q;
        end
    end
endmodule

// File: rtl/potbank_timer.sv
module potbank_timer #(
    parameter int BUSY_CYCLES = 500000,
    localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= CW'(BUSY_CYCLES - 1);
        end else if (running) begin
            if (cnt_q == '0) running <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign last = running && (cnt_q == '0);

    // R4: the window is never cut short before its last cycle
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last && !start) |=> running);
    // R4: a new window only opens when none is running
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);
endmodule

// File: rtl/potbank_seq.sv
module potbank_seq
    import potbank_pkg::*;
#(
    parameter int NUM_POTS    = 4,
    parameter int NUM_REGS    = 4,
    parameter int DW          = 6,
    parameter int INIT_BASE   = 5,
    parameter int BUSY_CYCLES = 500000,
    localparam int PW         = $clog2(NUM_POTS),
    localparam int RW         = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wp_n,
    input  logic                     cmd_valid,
    input  logic [3:0]               cmd_op,
    input  logic [PW-1:0]            cmd_pot,
    input  logic [RW-1:0]            cmd_reg,
    input  logic [DW-1:0]            cmd_data,
    input  logic                     bus_stop,
    output logic                     busy,
    output logic                     rd_valid,
    output logic [DW+1:0]            rd_data,
    output logic [NUM_POTS-1:0]      wiper_load,
    output logic [NUM_POTS*DW-1:0]   wiper_pos
);
    state_e state_q, state_d;

    logic [DW-1:0]                   wiper_q [NUM_POTS];
    logic [NUM_POTS*NUM_REGS*DW-1:0] set_all;
    logic [NUM_POTS-1:0]             set_we;
    logic [NUM_POTS*DW-1:0]          set_wdata;
    logic                            tmr_start, tmr_run, tmr_last;

    logic [3:0]    pend_op;
    logic [PW-1:0] pend_pot;
    logic [RW-1:0] pend_reg;
    logic [DW-1:0] pend_data;

    potbank_regfile #(
        .NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS), .DW(DW), .INIT_BASE(INIT_BASE)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .we(set_we), .wsel(pend_reg),
        .wdata(set_wdata), .rd_all(set_all)
    );

    potbank_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .running(tmr_run), .last(tmr_last)
    );

    function automatic logic [DW-1:0] set_at(input int p, input int r);
        return set_all[(p*NUM_REGS + r)*DW +: DW];
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RECALL;
        else        state_q <= state_d;
    end

    // next state and store control
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        set_we    = '0;
        for (int p = 0; p < NUM_POTS; p++)
            set_wdata[p*DW +: DW] = (pend_op == OP_WR_SET) ? pend_data : wiper_q[p];
        unique case (state_q)
            ST_RECALL: state_d = ST_IDLE;
            ST_IDLE: begin
                if (cmd_valid && is_store(cmd_op) && wp_n)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (bus_stop) begin
                    state_d   = ST_BUSY;
                    tmr_start = 1'b1;
                    if (pend_op == OP_G_W2S) set_we = '1;
                    else                     set_we[pend_pot] = 1'b1;
                end
            end
            ST_BUSY: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs and wipers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            wiper_load <= '0;
            pend_op    <= OP_NOP;
            pend_pot   <= '0;
            pend_reg   <= '0;
            pend_data  <= '0;
            for (int p = 0; p < NUM_POTS; p++) wiper_q[p] <= '0;
        end else begin
            rd_valid   <= 1'b0;
            wiper_load <= '0;
            if (state_q == ST_RECALL) begin
                for (int p = 0; p < NUM_POTS; p++) wiper_q[p] <= set_at(p, 0);
                wiper_load <= '1;
            end else if (state_q == ST_IDLE && cmd_valid) begin
                unique case (cmd_op)
                    OP_RD_WIP: begin
                        rd_data  <= {2'b00, wiper_q[cmd_pot]};
                        rd_valid <= 1'b1;
                    end
                    OP_RD_SET: begin
                        rd_data  <= {2'b00, set_at(int'(cmd_pot), int'(cmd_reg))};
                        rd_valid <= 1'b1;
                    end
                    OP_WR_WIP: begin
                        wiper_q[cmd_pot]    <= cmd_data;
                        wiper_load[cmd_pot] <= 1'b1;
                    end
                    OP_SET2WIP: begin
                        wiper_q[cmd_pot]    <= set_at(int'(cmd_pot), int'(cmd_reg));
                        wiper_load[cmd_pot] <= 1'b1;
                    end
                    OP_G_S2W: begin
                        for (int p = 0; p < NUM_POTS; p++)
                            wiper_q[p] <= set_at(p, int'(cmd_reg));
                        wiper_load <= '1;
                    end
                    OP_WR_SET, OP_WIP2SET, OP_G_W2S: begin
                        pend_op   <= cmd_op;
                        pend_pot  <= cmd_pot;
                        pend_reg  <= cmd_reg;
                        pend_data <= cmd_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_out
        assign wiper_pos[p*DW +: DW] = wiper_q[p];
    end

    assign busy = tmr_run || (state_q == ST_RECALL);

    // R1: the recall cycle loads every wiper
    p_recall_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECALL) |=> (wiper_load == '1));
    // R4: the stop pulse on an armed store opens the busy window
    p_stop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && bus_stop) |=> busy);
    // R9: protected stores never arm
    p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid && !wp_n) |=> (state_q == ST_IDLE && !busy));
    // R10: requests during a write window have no visible effect
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && cmd_valid) |=> (wiper_load == '0 && !rd_valid));
endmodule

// File: tb/test_potbank_seq.sv
module test_potbank_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_N     = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pot = '0;
    logic [1:0]  cmd_reg = '0;
    logic [5:0]  cmd_data = '0;
    logic        bus_stop = 1'b0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic [3:0]  wiper_load;
    logic [23:0] wiper_pos;

    int checks = 0;
    int failures = 0;
    logic [5:0] m_set [4][4];
    logic [5:0] m_wip [4];

    potbank_seq #(.BUSY_CYCLES(BUSY_N)) i_potbank_seq (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data), .bus_stop(bus_stop), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .wiper_load(wiper_load),
        .wiper_pos(wiper_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_load(input logic [3:0] op, input logic [1:0] p);
        if (op == 4'd2 || op == 4'd5) return 4'(1 << p);
        if (op == 4'd7) return 4'hF;
        return 4'h0;
    endfunction

    task automatic check_wipers(input string req, input logic [3:0] ld);
        for (int p = 0; p < 4; p++)
            check(wiper_pos[p*6 +: 6] == m_wip[p], req, wiper_pos[p*6 +: 6], m_wip[p]);
        check(wiper_load == ld, req, wiper_load, ld);
    endtask

    task automatic send(input logic [3:0] op, input logic [1:0] p, input logic [1:0] r,
                        input logic [5:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pot = p; cmd_reg = r; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stop_and_count(input string req, input int exp_n);
        int n = 0;
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_n, req, n, exp_n);
    endtask

    task automatic read_set(input string req, input logic [1:0] p, input logic [1:0] r);
        send(4'd3, p, r, 6'd0);
        check(rd_valid == 1'b1, req, rd_valid, 1);
        check(rd_data == {2'b00, m_set[p][r]}, req, rd_data, m_set[p][r]);
    endtask

    // one operation with model update and checks
    task automatic exec(input logic [3:0] op, input logic [1:0] p, input logic [1:0] r,
                        input logic [5:0] d);
        string req;
        logic [5:0] rd_exp = '0;
        logic is_rd = 1'b0;
        logic is_st;
        case (op)
            4'd1: begin req = "R3"; is_rd = 1'b1; rd_exp = m_wip[p]; end
            4'd3: begin req = "R3"; is_rd = 1'b1; rd_exp = m_set[p][r]; end
            4'd2: begin req = "R2"; m_wip[p] = d; end
            4'd5: begin req = "R5"; m_wip[p] = m_set[p][r]; end
            4'd7: begin req = "R7"; for (int q = 0; q < 4; q++) m_wip[q] = m_set[q][r]; end
            4'd4: req = wp_n ? "R4" : "R9";
            4'd6: req = wp_n ? "R6" : "R9";
            4'd8: req = wp_n ? "R8" : "R9";
            default: req = "R11";
        endcase
        is_st = (op == 4'd4 || op == 4'd6 || op == 4'd8);
        send(op, p, r, d);
        check(rd_valid == is_rd, req, rd_valid, is_rd);
        if (is_rd) check(rd_data == {2'b00, rd_exp}, req, rd_data, rd_exp);
        check_wipers(req, exp_load(op, p));
        if (is_st) begin
            if (wp_n) begin
                if (op == 4'd4) m_set[p][r] = d;
                if (op == 4'd6) m_set[p][r] = m_wip[p];
                if (op == 4'd8) for (int q = 0; q < 4; q++) m_set[q][r] = m_wip[q];
            end
            stop_and_count(req, wp_n ? BUSY_N : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) m_set[p][r] = 6'((p*4 + r + 5) % 64);
        for (int p = 0; p < 4; p++) m_wip[p] = m_set[p][0];

        // R1 reset and recall
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R1", busy, 1);
        check(rd_valid == 1'b0, "R1", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_wipers("R1", 4'hF);
        check(busy == 1'b0, "R1", busy, 0);

        // directed operations
        exec(4'd2, 2'd1, 2'd0, 6'd63);
        exec(4'd1, 2'd1, 2'd0, 6'd0);
        exec(4'd3, 2'd3, 2'd3, 6'd0);
        exec(4'd4, 2'd2, 2'd1, 6'd42);
        read_set("R4", 2'd2, 2'd1);
        exec(4'd5, 2'd2, 2'd1, 6'd0);
        exec(4'd6, 2'd1, 2'd2, 6'd0);
        read_set("R6", 2'd1, 2'd2);
        exec(4'd7, 2'd0, 2'd2, 6'd0);
        exec(4'd2, 2'd0, 2'd0, 6'd0);
        exec(4'd8, 2'd0, 2'd3, 6'd0);
        for (int p = 0; p < 4; p++) read_set("R8", 2'(p), 2'd3);
        exec(4'd12, 2'd0, 2'd0, 6'd9);
        exec(4'd0, 2'd3, 2'd0, 6'd9);

        // R9 write protect
        wp_n = 1'b0;
        exec(4'd4, 2'd0, 2'd0, 6'd1);
        read_set("R9", 2'd0, 2'd0);
        exec(4'd8, 2'd0, 2'd1, 6'd0);
        exec(4'd2, 2'd3, 2'd0, 6'd17);
        wp_n = 1'b1;

        // R10 requests while armed and while busy
        send(4'd4, 2'd3, 2'd0, 6'd33);
        m_set[3][0] = 6'd33;
        send(4'd2, 2'd3, 2'd0, 6'd5);
        check(wiper_load == 4'h0, "R10", wiper_load, 0);
        check(wiper_pos[18 +: 6] == m_wip[3], "R10", wiper_pos[18 +: 6], m_wip[3]);
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
        check(busy == 1'b1, "R10", busy, 1);
        send(4'd2, 2'd3, 2'd0, 6'd7);
        check(wiper_load == 4'h0, "R10", wiper_load, 0);
        send(4'd1, 2'd3, 2'd0, 6'd0);
        check(rd_valid == 1'b0, "R10", rd_valid, 0);
        check(wiper_pos[18 +: 6] == m_wip[3], "R10", wiper_pos[18 +: 6], m_wip[3]);
        while (busy) @(negedge clk);
        read_set("R10", 2'd3, 2'd0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 10));
            wp_n = ($urandom_range(0, 3) != 0);
            exec(op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 6'($urandom_range(0, 63)));
        end
        wp_n = 1'b1;
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) read_set("R3", 2'(p), 2'(r));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule